// File: doc/BRIEF.md
# Floppy Write Precompensation Selector

This block moves each write-data pulse bound for a floppy drive slightly earlier, slightly later, or leaves it at its nominal position. It works under two timing flags from the disk controller that mark the early and late cases. A rising edge on the write-data input latches a strobe high. The strobe starts an internal four-phase generator. The generator produces four one-clock phase pulses, spaced `GAP` clocks apart and counted from the strobe's rise. The timing flags are captured at the data edge and pick one of the first three phases as the output pulse. The fourth phase drops the strobe, which re-arms the block for the next data pulse.

Precompensation only applies in double density on the inner tracks. In single density, or on outer tracks, the block is bypassed and the write-data input drives the output directly, with no clock delay. Everything is synchronous to one clock. The data input is sampled, so its pulses must be at least one clock wide.

Top module: `wprecomp_sel`

## Requirements
- R1: After reset, `strobe_out`, `phase_out` and `wd_out` are all low.
- R2: Precompensation is enabled when `sd_sel` is 0 and `inner_in` is 1. In that mode, a 0-to-1 change of `wd_in` seen at a clock edge sets `strobe_out` from that edge on. Counting that edge as k=0, `phase_out[i]` is high for exactly the one clock that follows edge k=(i+1)*GAP. No phase is ever high while `strobe_out` is low.
- R3: With `early_in`=0 and `late_in`=0 at the data edge, `wd_out` repeats `phase_out[1]` during the sequence.
- R4: With only `early_in`=1, `wd_out` repeats `phase_out[0]`. With only `late_in`=1, it repeats `phase_out[2]`.
- R5: With `early_in`=1 and `late_in`=1 together, the pulse is placed as in R3 (nominal, `phase_out[1]`).
- R6: The edge on which `phase_out[3]` is high clears `strobe_out`, so the strobe is low from k=4*GAP+1.
- R7: With `sd_sel`=1 or `inner_in`=0, `wd_out` equals `wd_in` combinationally and `strobe_out` stays low.
- R8: `early_in` and `late_in` are sampled only at the data edge that sets the strobe. Changing them later in the sequence does not move the output pulse.
- R9: A `wd_in` rising edge that arrives while `strobe_out` is high is ignored. The sequence neither restarts nor lengthens.
- R10: In precompensation mode, `wd_out` is low whenever `strobe_out` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wd_in | input | 1 | Raw write-data pulse |
| early_in | input | 1 | Request to place the pulse early |
| late_in | input | 1 | Request to place the pulse late |
| sd_sel | input | 1 | 1 = single density (bypass) |
| inner_in | input | 1 | 1 = inner track (precompensation allowed) |
| strobe_out | output | 1 | Strobe that runs the phase sequence |
| phase_out | output | 4 | The four phase pulses, index 0 first |
| wd_out | output | 1 | Precompensated write data |

## Verification
The in-module assertions check on every cycle that the phases stay mutually exclusive and are silent while the strobe is low. They also check that a qualifying data edge raises the strobe, that the fourth phase drops it, that the captured selection holds steady through a sequence, and that the output is quiet outside a sequence in precompensation mode. Only the bench's scenarios can show that a given flag combination selects the right phase at the right clock. The same holds for late flag changes and mid-sequence data edges, which must leave the pulse where it was, and for the bypass path, which must follow the input with no delay.

// File: rtl/wprecomp_sel.sv
module wprecomp_sel #(
  parameter int GAP = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wd_in,
  input  logic       early_in,
  input  logic       late_in,
  input  logic       sd_sel,
  input  logic       inner_in,
  output logic       strobe_out,
  output logic [3:0] phase_out,
  output logic       wd_out
);
  localparam int LAST = 4 * GAP;
  localparam int CW   = $clog2(LAST + 1);

  logic          wd_q;
  logic          stb_q;
  logic [CW-1:0] cnt;
  logic [1:0]    sel;

  wire en   = !sd_sel && inner_in;
  wire lead = wd_in && !wd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wd_q  <= 1'b0;
      stb_q <= 1'b0;
      cnt   <= '0;
      sel   <= 2'd1;
    end else begin
      wd_q <= wd_in;
      if (stb_q) begin
        if (cnt == CW'(LAST)) stb_q <= 1'b0;
        else                  cnt   <= cnt + 1'b1;
      end else if (lead && en) begin
        stb_q <= 1'b1;
        cnt   <= '0;
        sel   <= (early_in && !late_in) ? 2'd0 :
                 (late_in && !early_in) ? 2'd2 : 2'd1;
      end
    end
  end

  for (genvar k = 0; k < 4; k++) begin : g_ph
    assign phase_out[k] = stb_q && (cnt == CW'((k + 1) * GAP));
  end

  assign strobe_out = stb_q;
  assign wd_out     = stb_q ? phase_out[sel] : (en ? 1'b0 : wd_in);

  AST_PH_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(phase_out)); // R2
  AST_PH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe_out |-> phase_out == 4'b0); // R2
  AST_STB_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (lead && en && !strobe_out) |=> strobe_out); // R2
  AST_STB_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    phase_out[3] |=> !strobe_out); // R6
  AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_out && $past(strobe_out)) |-> $stable(sel)); // R8
  AST_OUT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !strobe_out) |-> !wd_out); // R10
  AST_NO_RETRIG: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_out && !phase_out[3]) |=> strobe_out); // R9
endmodule

// File: tb/wprecomp_sel_bench.sv
module wprecomp_sel_bench;
  localparam int G = 2;
  localparam int LAST = 4 * G;

  logic clk = 0, rst_n = 0;
  logic wd_in = 0, early_in = 0, late_in = 0, sd_sel = 0, inner_in = 1;
  logic strobe_out, wd_out;
  logic [3:0] phase_out;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  wprecomp_sel #(.GAP(G)) u_wprecomp_sel (
    .clk, .rst_n, .wd_in, .early_in, .late_in, .sd_sel, .inner_in,
    .strobe_out, .phase_out, .wd_out
  );

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // one precompensated pulse; idx = expected phase index
  task automatic run_seq(input string req, input logic e, input logic l, input int idx,
                         input bit flip, input bit retrig);
    @(negedge clk);
    wd_in = 1; early_in = e; late_in = l;
    @(posedge clk);
    for (int k = 0; k <= LAST + 2; k++) begin
      @(negedge clk);
      chk({req, " strobe"}, {3'b0, strobe_out}, {3'b0, k <= LAST});
      chk({req, " wd_out"}, {3'b0, wd_out}, {3'b0, k == (idx + 1) * G});
      chk("R2 phases", phase_out,
          (k >= G && k <= LAST && k % G == 0) ? 4'(1 << (k / G - 1)) : 4'b0);
      if (k == 0) begin
        wd_in = 0;
        if (flip) begin early_in = ~e; late_in = ~l; end
      end
      if (retrig && k == 3) wd_in = 1;
      if (retrig && k == 4) wd_in = 0;
    end
    early_in = 0; late_in = 0;
  endtask

  task automatic run_bypass(input string req, input logic sd, input logic inner);
    @(negedge clk);
    sd_sel = sd; inner_in = inner;
    wd_in = 1;
    #1 chk({req, " follow high"}, {3'b0, wd_out}, 4'h1);
    @(negedge clk);
    chk({req, " strobe low"}, {3'b0, strobe_out}, 4'h0);
    chk({req, " no phases"}, phase_out, 4'h0);
    wd_in = 0;
    #1 chk({req, " follow low"}, {3'b0, wd_out}, 4'h0);
    @(negedge clk);
    sd_sel = 0; inner_in = 1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 strobe", {3'b0, strobe_out}, 4'h0);
    chk("R1 phases", phase_out, 4'h0);
    chk("R1 wd_out", {3'b0, wd_out}, 4'h0);
    rst_n = 1;
    @(negedge clk);
    chk("R10 idle out", {3'b0, wd_out}, 4'h0);
    run_seq("R3 nominal", 0, 0, 1, 0, 0);
    run_seq("R4 early", 1, 0, 0, 0, 0);
    run_seq("R4 late", 0, 1, 2, 0, 0);
    run_seq("R5 both", 1, 1, 1, 0, 0);
    run_seq("R8 flip early", 1, 0, 0, 1, 0);
    run_seq("R8 flip late", 0, 1, 2, 1, 0);
    run_seq("R9 retrigger", 0, 0, 1, 0, 1);
    run_seq("R6 rearm", 0, 1, 2, 0, 0);
    run_bypass("R7 single density", 1, 1);
    run_bypass("R7 outer track", 0, 0);
    run_seq("R2 after bypass", 0, 0, 1, 0, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule